// File: doc/BRIEF.md
# Boost Frequency Governor Datapath

This block turns the breach events of an activity monitor into a memory-clock request. For each monitored traffic source it holds a boost value. An upper-breach event grows the boost by a percentage and then adds a fixed step. A lower-breach event shrinks the boost by a percentage, and the boost drops to zero once it falls below half a step. After each update the block decides which of the monitor's consecutive-breach detectors to re-arm. It also works out new raw and average watermarks for the monitor.

One `start_i` pulse runs a complete pass. The block samples every input on that edge. It then handles the sources one after the other, using one shared sequential divider. For each source it produces a target frequency from the latest average count, the source's boost and, where it applies, a floor derived from the CPU frequency. The request reported in `target_o` is the largest of the per-source targets, and `done_o` pulses for one cycle when the pass ends. A start that arrives while a pass is running is ignored. Frequencies are in kHz. The average counts cover one sampling period of `SAMPLE_MS` milliseconds. Coefficients and thresholds are given in percent.

Top module: `boost_gov`

## Requirements
- R1: If a source's upper flag is set, its boost becomes boost*up_coeff/100 + 16000. If the result is at or above the maximum frequency, the boost becomes the maximum frequency and above_en is 0; otherwise above_en is 1. below_en is 1 in both cases.
- R2: If only a source's lower flag is set, its boost becomes boost*down_coeff/100. If the result is below 8000, the boost becomes 0 and below_en is 0; otherwise below_en is 1. above_en is 1 in both cases.
- R3: If both flags of a source are set, only the upper-flag rule (R1) applies.
- R4: If a source's dependency threshold is nonzero, then after the event rule below_en is forced to 1 when avg is at or above the threshold. Otherwise below_en is forced to 0 when the boost is 0. With no flag and a zero threshold, the boost and both enables keep their values.
- R5: The per-source target is ((avg/12)*(10000/up_thr))/100 + boost, truncated at each step. When the dependency threshold is nonzero and avg is at or above it, the target is raised to at least the CPU floor.
- R6: The CPU floor is taken from the first row of this descending table whose CPU value is at or below cpu_freq: 1400000 gives the maximum frequency, 1200000 gives 750000, 1100000 gives 600000, 1000000 gives 500000, 800000 gives 375000, 500000 gives 200000, 250000 gives 100000. The result is limited to the maximum frequency, and it is 0 when no row matches.
- R7: wm_up = cur*12*up_thr/100 and wm_lo = cur*12*down_thr/100 for each source.
- R8: With band = (max*6/1000)*12, avg_wm_up = avg + band and avg_wm_lo = max(avg, band) - band.
- R9: target_o is the largest per-source target. All inputs are sampled on the start edge. done_o is a single-cycle pulse that ends the pass, and a start while busy_o is high is ignored.
- R10: After reset every boost is 0, every enable is 1, and target_o and all watermarks are 0.
- R11: A boost is always either 0 or at least 8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a pass; inputs are sampled here |
| up_evt_i | input | N | Upper consecutive-breach flag per source |
| lo_evt_i | input | N | Lower consecutive-breach flag per source |
| avg_i | input | N*DW | Average count per source |
| cur_freq_i | input | DW | Current memory frequency |
| max_freq_i | input | DW | Maximum memory frequency |
| cpu_freq_i | input | DW | CPU frequency |
| up_coeff_i | input | N*CW | Boost growth percent per source |
| down_coeff_i | input | N*CW | Boost decay percent per source |
| up_thr_i | input | N*CW | Upper watermark percent per source (nonzero) |
| down_thr_i | input | N*CW | Lower watermark percent per source |
| dep_thr_i | input | N*DW | Dependency threshold per source (0 turns it off) |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass strobe |
| target_o | output | DW | Requested frequency |
| boost_o | output | N*DW | Boost per source |
| above_en_o | output | N | Above-breach detector arm per source |
| below_en_o | output | N | Below-breach detector arm per source |
| wm_up_o | output | N*DW | Raw upper watermark per source |
| wm_lo_o | output | N*DW | Raw lower watermark per source |
| avg_wm_up_o | output | N*DW | Average upper watermark per source |
| avg_wm_lo_o | output | N*DW | Average lower watermark per source |

## Verification
The bench builds the block with its defaults: two sources, 32-bit values, 16-bit coefficients, a 16000 step and a 12 ms period. Two sources are enough to exercise the serial maximum, and they give one source with the dependency floor and one without. The 32-bit width limits the bench to maximum frequencies up to 2000000 and up_thr of at least 10, so that no product overflows. Inside that range the clamp at a small maximum, decay down to zero, and every boundary of the CPU floor table can all be reached.

// File: rtl/boost_gov_pkg.sv
package boost_gov_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BAND, ST_BOOST, ST_AVG, ST_SUS, ST_TGT, ST_WUP, ST_WLO
  } gov_st_e;

  localparam int FLOOR_ROWS = 7;
  // CPU threshold rows in descending order; all-ones value means "use max"
  localparam logic [31:0] FLOOR_CPU [FLOOR_ROWS] = '{
    32'd1400000, 32'd1200000, 32'd1100000, 32'd1000000,
    32'd800000,  32'd500000,  32'd250000};
  localparam logic [31:0] FLOOR_VAL [FLOOR_ROWS] = '{
    32'hFFFF_FFFF, 32'd750000, 32'd600000, 32'd500000,
    32'd375000,    32'd200000, 32'd100000};
endpackage

// File: rtl/boost_gov_div.sv
module boost_gov_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CNTW = $clog2(W + 1);

  logic [W:0]      rem_q, sh, diff;
  logic [W-1:0]    quo_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q, done_q;

  always_comb begin
    sh   = {rem_q[W-1:0], quo_q[W-1]};
    diff = sh - {1'b0, den_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        cnt_q <= CNTW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!diff[W]) begin
          rem_q <= diff;
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= sh;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/boost_gov_floor.sv
module boost_gov_floor
  import boost_gov_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cpu_i,
  input  logic [DW-1:0] max_i,
  output logic [DW-1:0] floor_o
);
  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = FLOOR_ROWS - 1; i >= 0; i--) begin
      if (cpu_i >= DW'(FLOOR_CPU[i])) pick = DW'(FLOOR_VAL[i]);
    end
    floor_o = (pick >= max_i) ? max_i : pick;
  end
endmodule

// File: rtl/boost_gov.sv
module boost_gov
  import boost_gov_pkg::*;
#(
  parameter int N             = 2,
  parameter int DW            = 32,
  parameter int CW            = 16,
  parameter int BOOST_STEP    = 16000,
  parameter int SAMPLE_MS     = 12,
  parameter int BAND_PERMILLE = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]    up_evt_i,
  input  logic [N-1:0]    lo_evt_i,
  input  logic [N*DW-1:0] avg_i,
  input  logic [DW-1:0]   cur_freq_i,
  input  logic [DW-1:0]   max_freq_i,
  input  logic [DW-1:0]   cpu_freq_i,
  input  logic [N*CW-1:0] up_coeff_i,
  input  logic [N*CW-1:0] down_coeff_i,
  input  logic [N*CW-1:0] up_thr_i,
  input  logic [N*CW-1:0] down_thr_i,
  input  logic [N*DW-1:0] dep_thr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   target_o,
  output logic [N*DW-1:0] boost_o,
  output logic [N-1:0]    above_en_o,
  output logic [N-1:0]    below_en_o,
  output logic [N*DW-1:0] wm_up_o,
  output logic [N*DW-1:0] wm_lo_o,
  output logic [N*DW-1:0] avg_wm_up_o,
  output logic [N*DW-1:0] avg_wm_lo_o
);
  localparam int SW        = (N > 1) ? $clog2(N) : 1;
  localparam int HALF_STEP = BOOST_STEP / 2;

  gov_st_e st_q;
  logic    wait_q, done_q;
  logic [SW-1:0] src_q;

  logic [DW-1:0] boost_q [N];
  logic [N-1:0]  above_q, below_q, upe_q, loe_q;
  logic [DW-1:0] wmu_q [N], wml_q [N], awu_q [N], awl_q [N];
  logic [DW-1:0] avg_q [N], uc_q [N], dc_q [N], ut_q [N], dt_q [N], dep_q [N];
  logic [DW-1:0] cur_q, max_q, cpu_q, band_q, a12_q, sus_q, acc_q, tgt_q;

  logic          div_start, div_done;
  logic [DW-1:0] div_num, div_den, div_q, floor_v;
  logic [DW-1:0] s_avg, s_boost, s_dep, nb, t_raw, t_fin;
  logic          s_up, s_lo, na, nl, skip_div;

  assign s_avg   = avg_q[src_q];
  assign s_boost = boost_q[src_q];
  assign s_dep   = dep_q[src_q];
  assign s_up    = upe_q[src_q];
  assign s_lo    = loe_q[src_q];
  assign skip_div = (st_q == ST_BOOST) && !s_up && !s_lo;
  assign div_start = (st_q != ST_IDLE) && !wait_q && !skip_div;

  always_comb begin
    div_num = '0;
    div_den = DW'(100);
    unique case (st_q)
      ST_BAND:  begin div_num = max_q * DW'(BAND_PERMILLE); div_den = DW'(1000); end
      ST_BOOST: div_num = s_boost * (s_up ? uc_q[src_q] : dc_q[src_q]);
      ST_AVG:   begin div_num = s_avg; div_den = DW'(SAMPLE_MS); end
      ST_SUS:   begin div_num = DW'(10000); div_den = ut_q[src_q]; end
      ST_TGT:   div_num = a12_q * sus_q;
      ST_WUP:   div_num = cur_q * DW'(SAMPLE_MS) * ut_q[src_q];
      ST_WLO:   div_num = cur_q * DW'(SAMPLE_MS) * dt_q[src_q];
      default:  ;
    endcase
  end

  boost_gov_div #(.W(DW)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .num_i(div_num), .den_i(div_den),
    .done_o(div_done), .quo_o(div_q)
  );

  boost_gov_floor #(.DW(DW)) u_floor (.cpu_i(cpu_q), .max_i(max_q), .floor_o(floor_v));

  // boost and re-arm decision for the current source
  always_comb begin
    nb = s_boost;
    na = above_q[src_q];
    nl = below_q[src_q];
    if (s_up) begin
      nl = 1'b1;
      if (div_q + DW'(BOOST_STEP) >= max_q) begin
        nb = max_q;
        na = 1'b0;
      end else begin
        nb = div_q + DW'(BOOST_STEP);
        na = 1'b1;
      end
    end else if (s_lo) begin
      na = 1'b1;
      if (div_q < DW'(HALF_STEP)) begin
        nb = '0;
        nl = 1'b0;
      end else begin
        nb = div_q;
        nl = 1'b1;
      end
    end
    if (s_dep != '0) begin
      if (s_avg >= s_dep) nl = 1'b1;
      else if (nb == '0)  nl = 1'b0;
    end
    t_raw = div_q + s_boost;
    t_fin = (s_dep != '0 && s_avg >= s_dep && floor_v > t_raw) ? floor_v : t_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      wait_q <= 1'b0;
      done_q <= 1'b0;
      src_q <= '0;
      {cur_q, max_q, cpu_q, band_q, a12_q, sus_q, acc_q, tgt_q} <= '0;
      above_q <= '1;
      below_q <= '1;
      upe_q <= '0;
      loe_q <= '0;
      for (int i = 0; i < N; i++) begin
        boost_q[i] <= '0; wmu_q[i] <= '0; wml_q[i] <= '0;
        awu_q[i] <= '0; awl_q[i] <= '0; avg_q[i] <= '0;
        uc_q[i] <= '0; dc_q[i] <= '0; ut_q[i] <= '0; dt_q[i] <= '0; dep_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q  <= ST_BAND;
          src_q <= '0;
          acc_q <= '0;
          cur_q <= cur_freq_i;
          max_q <= max_freq_i;
          cpu_q <= cpu_freq_i;
          upe_q <= up_evt_i;
          loe_q <= lo_evt_i;
          for (int i = 0; i < N; i++) begin
            avg_q[i] <= avg_i[i*DW +: DW];
            dep_q[i] <= dep_thr_i[i*DW +: DW];
            uc_q[i]  <= DW'(up_coeff_i[i*CW +: CW]);
            dc_q[i]  <= DW'(down_coeff_i[i*CW +: CW]);
            ut_q[i]  <= DW'(up_thr_i[i*CW +: CW]);
            dt_q[i]  <= DW'(down_thr_i[i*CW +: CW]);
          end
        end
      end else if (skip_div) begin
        below_q[src_q] <= nl;
        st_q <= ST_AVG;
      end else if (!wait_q) begin
        wait_q <= 1'b1;
      end else if (div_done) begin
        wait_q <= 1'b0;
        unique case (st_q)
          ST_BAND: begin band_q <= div_q * DW'(SAMPLE_MS); st_q <= ST_BOOST; end
          ST_BOOST: begin
            boost_q[src_q] <= nb;
            above_q[src_q] <= na;
            below_q[src_q] <= nl;
            st_q <= ST_AVG;
          end
          ST_AVG: begin
            a12_q <= div_q;
            awu_q[src_q] <= s_avg + band_q;
            awl_q[src_q] <= ((s_avg > band_q) ? s_avg : band_q) - band_q;
            st_q <= ST_SUS;
          end
          ST_SUS: begin sus_q <= div_q; st_q <= ST_TGT; end
          ST_TGT: begin
            if (t_fin > acc_q) acc_q <= t_fin;
            st_q <= ST_WUP;
          end
          ST_WUP: begin wmu_q[src_q] <= div_q; st_q <= ST_WLO; end
          ST_WLO: begin
            wml_q[src_q] <= div_q;
            if (src_q == SW'(N - 1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              tgt_q  <= acc_q;
            end else begin
              src_q <= src_q + SW'(1);
              st_q  <= ST_BOOST;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign target_o   = tgt_q;
  assign above_en_o = above_q;
  assign below_en_o = below_q;

  for (genvar g = 0; g < N; g++) begin : g_out
    assign boost_o[g*DW +: DW]     = boost_q[g];
    assign wm_up_o[g*DW +: DW]     = wmu_q[g];
    assign wm_lo_o[g*DW +: DW]     = wml_q[g];
    assign avg_wm_up_o[g*DW +: DW] = awu_q[g];
    assign avg_wm_lo_o[g*DW +: DW] = awl_q[g];
  end
endmodule

// File: rtl/boost_gov_chk.sv
module boost_gov_chk #(
  parameter int N    = 2,
  parameter int DW   = 32,
  parameter int STEP = 16000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [DW-1:0]   target_o,
  input logic [N*DW-1:0] boost_o,
  input logic [N*DW-1:0] avg_wm_up_o,
  input logic [N*DW-1:0] avg_wm_lo_o
);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_start_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_target_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(target_o));

  for (genvar g = 0; g < N; g++) begin : g_src
    assert_boost_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boost_o[g*DW +: DW] == '0) || (boost_o[g*DW +: DW] >= DW'(STEP / 2)));
    assert_avg_wm_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      avg_wm_lo_o[g*DW +: DW] <= avg_wm_up_o[g*DW +: DW]);
  end
endmodule

bind boost_gov boost_gov_chk #(.N(N), .DW(DW), .STEP(BOOST_STEP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .target_o(target_o), .boost_o(boost_o),
  .avg_wm_up_o(avg_wm_up_o), .avg_wm_lo_o(avg_wm_lo_o)
);

// File: tb/boost_gov_test.sv
module boost_gov_test;
  localparam int N = 2, DW = 32, CW = 16;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [N-1:0] up_evt, lo_evt;
  logic [DW-1:0] avg_a [N], dep_a [N];
  logic [CW-1:0] uc_a [N], dc_a [N], ut_a [N], dt_a [N];
  logic [DW-1:0] cur_f, max_f, cpu_f;
  logic [N*DW-1:0] avg_flat, dep_flat;
  logic [N*CW-1:0] uc_flat, dc_flat, ut_flat, dt_flat;
  logic busy_o, done_o;
  logic [DW-1:0] target_o;
  logic [N*DW-1:0] boost_o, wm_up_o, wm_lo_o, avg_wm_up_o, avg_wm_lo_o;
  logic [N-1:0] above_en_o, below_en_o;

  int checks = 0, errors = 0, cyc = 0;

  longint m_b [N];
  bit m_a [N], m_l [N];

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      avg_flat[i*DW +: DW] = avg_a[i];
      dep_flat[i*DW +: DW] = dep_a[i];
      uc_flat[i*CW +: CW]  = uc_a[i];
      dc_flat[i*CW +: CW]  = dc_a[i];
      ut_flat[i*CW +: CW]  = ut_a[i];
      dt_flat[i*CW +: CW]  = dt_a[i];
    end
  end

  boost_gov uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .up_evt_i(up_evt), .lo_evt_i(lo_evt),
    .avg_i(avg_flat), .cur_freq_i(cur_f), .max_freq_i(max_f), .cpu_freq_i(cpu_f),
    .up_coeff_i(uc_flat), .down_coeff_i(dc_flat), .up_thr_i(ut_flat), .down_thr_i(dt_flat),
    .dep_thr_i(dep_flat), .busy_o(busy_o), .done_o(done_o), .target_o(target_o),
    .boost_o(boost_o), .above_en_o(above_en_o), .below_en_o(below_en_o),
    .wm_up_o(wm_up_o), .wm_lo_o(wm_lo_o), .avg_wm_up_o(avg_wm_up_o), .avg_wm_lo_o(avg_wm_lo_o)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint cpu_floor(longint cpu, longint mx);
    longint th [7] = '{1400000, 1200000, 1100000, 1000000, 800000, 500000, 250000};
    longint vl [7] = '{-1, 750000, 600000, 500000, 375000, 200000, 100000};
    longint f = 0;
    for (int i = 0; i < 7; i++) begin
      if (cpu >= th[i]) begin
        f = (vl[i] < 0) ? mx : vl[i];
        break;
      end
    end
    return (f >= mx) ? mx : f;
  endfunction

  task automatic set_defaults();
    uc_a[0] = 200; dc_a[0] = 50; ut_a[0] = 60; dt_a[0] = 40; dep_a[0] = 0;
    uc_a[1] = 800; dc_a[1] = 90; ut_a[1] = 27; dt_a[1] = 10; dep_a[1] = 50000;
  endtask

  task automatic run(input logic [N-1:0] up, input logic [N-1:0] lo,
                     input longint av0, input longint av1, input longint cur,
                     input longint mx, input longint cpu, input string ttag);
    longint av [N], e_t, t, band, e_wu [N], e_wl [N], e_au [N], e_al [N];
    string tg [N];
    av[0] = av0; av[1] = av1;
    band = (mx * 6 / 1000) * 12;
    e_t = 0;
    for (int i = 0; i < N; i++) begin
      if (up[i] && lo[i]) tg[i] = "R3";
      else if (up[i])     tg[i] = "R1";
      else if (lo[i])     tg[i] = "R2";
      else                tg[i] = "R4";
      if (up[i]) begin
        m_b[i] = m_b[i] * longint'(uc_a[i]) / 100 + 16000;
        m_l[i] = 1;
        if (m_b[i] >= mx) begin m_b[i] = mx; m_a[i] = 0; end
        else m_a[i] = 1;
      end else if (lo[i]) begin
        m_b[i] = m_b[i] * longint'(dc_a[i]) / 100;
        m_a[i] = 1;
        if (m_b[i] < 8000) begin m_b[i] = 0; m_l[i] = 0; end
        else m_l[i] = 1;
      end
      if (dep_a[i] != 0) begin
        if (av[i] >= longint'(dep_a[i])) m_l[i] = 1;
        else if (m_b[i] == 0) m_l[i] = 0;
      end
      t = ((av[i] / 12) * (10000 / longint'(ut_a[i]))) / 100 + m_b[i];
      if (dep_a[i] != 0 && av[i] >= longint'(dep_a[i]) && cpu_floor(cpu, mx) > t)
        t = cpu_floor(cpu, mx);
      if (t > e_t) e_t = t;
      e_wu[i] = cur * 12 * longint'(ut_a[i]) / 100;
      e_wl[i] = cur * 12 * longint'(dt_a[i]) / 100;
      e_au[i] = av[i] + band;
      e_al[i] = ((av[i] > band) ? av[i] : band) - band;
    end

    @(negedge clk);
    up_evt = up; lo_evt = lo; avg_a[0] = DW'(av0); avg_a[1] = DW'(av1);
    cur_f = DW'(cur); max_f = DW'(mx); cpu_f = DW'(cpu);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // inputs change after the start edge; a second start while busy must be ignored
    up_evt = ~up; lo_evt = ~lo; avg_a[0] = $urandom; avg_a[1] = $urandom;
    cur_f = $urandom; max_f = $urandom; cpu_f = $urandom;
    repeat (20) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);

    chk(ttag, target_o, e_t);
    for (int i = 0; i < N; i++) begin
      chk(tg[i], boost_o[i*DW +: DW], m_b[i]);
      chk(tg[i], above_en_o[i], m_a[i]);
      chk((dep_a[i] != 0) ? "R4" : tg[i], below_en_o[i], m_l[i]);
      chk("R7", wm_up_o[i*DW +: DW], e_wu[i]);
      chk("R7", wm_lo_o[i*DW +: DW], e_wl[i]);
      chk("R8", avg_wm_up_o[i*DW +: DW], e_au[i]);
      chk("R8", avg_wm_lo_o[i*DW +: DW], e_al[i]);
      chk("R11", (m_b[i] == 0 || m_b[i] >= 8000) ? 1 : 0, 1);
    end
    repeat (3) begin
      @(negedge clk);
      chk("R9", {busy_o, done_o}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    up_evt = '0; lo_evt = '0; cur_f = '0; max_f = '0; cpu_f = '0;
    for (int i = 0; i < N; i++) begin
      avg_a[i] = '0; m_b[i] = 0; m_a[i] = 1; m_l[i] = 1;
    end
    set_defaults();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", boost_o, 0);
    chk("R10", above_en_o, 2'b11);
    chk("R10", below_en_o, 2'b11);
    chk("R10", target_o, 0);
    chk("R10", wm_up_o, 0);
    chk("R10", avg_wm_lo_o, 0);
    chk("R10", busy_o, 0);

    // R3 both flags, R1 clamp at small max, R2 decay to zero
    run(2'b11, 2'b11, 1000, 1000, 400000, 2000000, 0, "R3");
    run(2'b11, 2'b00, 1000, 1000, 10000, 20000, 0, "R1");
    run(2'b00, 2'b11, 1000, 100, 10000, 2000000, 0, "R2");
    run(2'b00, 2'b11, 70000, 60000, 10000, 2000000, 0, "R2");
    run(2'b00, 2'b11, 900, 100, 10000, 2000000, 0, "R4");
    // R6 floor table edges on source 1 (avg at or above dependency threshold)
    run(2'b00, 2'b00, 0, 60000, 300000, 900000, 1400000, "R6");
    run(2'b00, 2'b00, 0, 60000, 300000, 900000, 1399999, "R6");
    run(2'b00, 2'b00, 0, 60000, 300000, 900000, 250000, "R6");
    run(2'b00, 2'b00, 0, 60000, 300000, 900000, 249999, "R6");
    run(2'b00, 2'b00, 0, 49999, 300000, 900000, 1400000, "R5");

    for (int k = 0; k < 110; k++) begin
      longint mx, cur;
      if (k % 4 == 3) begin
        for (int i = 0; i < N; i++) begin
          ut_a[i] = CW'(10 + $urandom_range(0, 90));
          dt_a[i] = CW'($urandom_range(0, 100));
          uc_a[i] = CW'($urandom_range(50, 800));
          dc_a[i] = CW'($urandom_range(0, 99));
        end
      end else set_defaults();
      mx  = $urandom_range(100000, 2000000);
      cur = $urandom_range(0, 32'(mx));
      run(2'($urandom), 2'($urandom), $urandom_range(0, 1 << 20), $urandom_range(0, 1 << 20),
          cur, mx, $urandom_range(0, 1600000), "R5");
    end

    summary();
    $finish;
  end
endmodule